// File: doc/BRIEF.md
# Reference and Mode Select Controller

This block decides how a clock synchronizer runs and which reference input it follows. It produces a decoded operating mode (free run, locked or holdover) and a one-hot selection over eight numbered references plus one cross-couple reference used when a partner unit is the timing master. The selection code comes either from four hardware select pins or from a small internal control register. A hardware-override pin picks between the two. While the pins are in charge, writes to the register are dropped.

A master/slave pin overrides both sources. In slave mode the block always locks to the cross-couple reference. After every reset the synchronizer's configuration has to be loaded again. The block holds the mode at free run until a load-complete pulse arrives, and it records which source, bus or EEPROM, supplied that load. A readback word reports the mode, code and reference actually in effect, so software sees the pin-derived values while the pins have control.

Top module: `ref_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is free run (00), `ref_sel_o` is all zeros, `cfg_valid_o` is 0 and `reg_rdata_o` is 0.
- R2: An effective select code of 0000 gives mode free run (00) with no reference bit set.
- R3: An effective select code k from 0001 to 1000 gives mode locked (01) with only `ref_sel_o[k-1]` set.
- R4: Effective select codes 1001 to 1111 give mode holdover (10) with no reference bit set.
- R5: While the synchronized override pin is 1, the effective code is the synchronized select pins, and register writes are ignored. After override is released, the register still holds its earlier value.
- R6: While the synchronized override pin is 0, the effective code is the control register. A write captured at one clock edge shows on `mode_o` and `ref_sel_o` at the next edge.
- R7: When configuration is valid and the synchronized master/slave pin is 0 (slave), the mode is locked (01) and only `ref_sel_o[8]`, the cross-couple reference, is set, whatever the pins or register hold.
- R8: Until a `cfg_done_i` pulse arrives after reset, `cfg_valid_o` stays 0 and the block is held at free run with no reference. The pulse sets `cfg_valid_o`, which then stays 1 until the next reset. The pulse also captures `cfg_src_i` (0 = bus, 1 = EEPROM).
- R9: The override, master/slave and select pins pass through a two-flop synchronizer. A pin change shows on the outputs at the third rising clock edge after it.
- R10: `reg_rdata_o` is {cfg_valid, cfg_src, cross-couple active, mode[1:0], effective code[3:0]}, with bit 8 as the MSB. It reflects the values in effect.
- R11: At most one bit of `ref_sel_o` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_ovr_i | input | 1 | 1 = select pins control mode and reference |
| master_i | input | 1 | 1 = master, 0 = slave |
| sel_i | input | SEL_W | Hardware select code |
| cfg_src_i | input | 1 | Configuration source: 0 = bus, 1 = EEPROM |
| cfg_done_i | input | 1 | Single-cycle pulse: configuration load complete |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | SEL_W | Control register write data (select code) |
| mode_o | output | 2 | 00 free run, 01 locked, 10 holdover |
| ref_sel_o | output | NUM_REF+1 | One-hot reference; top bit is the cross-couple reference |
| cfg_valid_o | output | 1 | Configuration loaded since reset |
| reg_rdata_o | output | SEL_W+5 | Readback word |

## Verification
The bench builds the block with its defaults: four select bits, eight references and two synchronizer stages. With these values, each of the sixteen codes maps onto one of the three decode regions, including both edges of the locked range. The bench drives every code from the register and again from the pins. It counts the three-edge pin latency edge by edge. It also confirms that a write dropped under override leaves the register value intact once override is released.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_LOCK = 2'b01,
        MODE_HOLD = 2'b10
    } mode_e;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= '0;
            else         stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/refsel_decode.sv
module refsel_decode
    import refsel_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int NUM_REF = 8
) (
    input  logic [SEL_W-1:0]   code_i,
    output mode_e              mode_o,
    output logic [NUM_REF-1:0] ref_o
);

    localparam logic [SEL_W-1:0] LOCK_MAX = SEL_W'(NUM_REF);

    always_comb begin
        if (code_i == '0)            mode_o = MODE_FREE;
        else if (code_i <= LOCK_MAX) mode_o = MODE_LOCK;
        else                         mode_o = MODE_HOLD;
    end

    for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
        localparam logic [SEL_W-1:0] MY_CODE = SEL_W'(g + 1);
        assign ref_o[g] = (code_i == MY_CODE);
    end

endmodule

// File: rtl/refsel_cfg.sv
module refsel_cfg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic done_i,
    input  logic src_i,
    output logic valid_o,
    output logic src_o
);

    typedef struct packed {
        logic valid;
        logic src;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (done_i) begin
            cfg_d.valid = 1'b1;
            cfg_d.src   = src_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign valid_o = cfg_q.valid;
    assign src_o   = cfg_q.src;

endmodule

// File: rtl/ref_mode_ctrl.sv
module ref_mode_ctrl
    import refsel_pkg::*;
#(
    parameter int SEL_W       = 4,
    parameter int NUM_REF     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               hw_ovr_i,
    input  logic               master_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               cfg_src_i,
    input  logic               cfg_done_i,
    input  logic               reg_wr_i,
    input  logic [SEL_W-1:0]   reg_wdata_i,
    output logic [1:0]         mode_o,
    output logic [NUM_REF:0]   ref_sel_o,
    output logic               cfg_valid_o,
    output logic [SEL_W+4:0]   reg_rdata_o
);

    localparam int PIN_W = SEL_W + 2;

    typedef struct packed {
        logic [SEL_W-1:0]   ctrl;
        logic [SEL_W-1:0]   code;
        mode_e              mode;
        logic [NUM_REF-1:0] refs;
        logic               xref;
    } state_t;

    state_t st_d, st_q;

    logic [PIN_W-1:0]   pins_s;
    logic               hw_s;
    logic               master_s;
    logic [SEL_W-1:0]   sel_s;
    logic [SEL_W-1:0]   src_code;
    mode_e              dec_mode;
    logic [NUM_REF-1:0] dec_refs;
    logic               cfg_src;
    logic [SEL_W-1:0]   ctrl_now;

    refsel_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({hw_ovr_i, master_i, sel_i}),
        .q_o    (pins_s)
    );

    assign hw_s     = pins_s[PIN_W-1];
    assign master_s = pins_s[PIN_W-2];
    assign sel_s    = pins_s[SEL_W-1:0];

    refsel_cfg u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .done_i  (cfg_done_i),
        .src_i   (cfg_src_i),
        .valid_o (cfg_valid_o),
        .src_o   (cfg_src)
    );

    // Source arbitration: pins win while override is active
    assign src_code = hw_s ? sel_s : st_q.ctrl;

    refsel_decode #(
        .SEL_W   (SEL_W),
        .NUM_REF (NUM_REF)
    ) u_dec (
        .code_i (src_code),
        .mode_o (dec_mode),
        .ref_o  (dec_refs)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr_i && !hw_s) begin
            st_d.ctrl = reg_wdata_i;
        end
        st_d.code = src_code;
        if (!cfg_valid_o) begin
            st_d.mode = MODE_FREE;
            st_d.refs = '0;
            st_d.xref = 1'b0;
        end else if (!master_s) begin
            st_d.mode = MODE_LOCK;
            st_d.refs = '0;
            st_d.xref = 1'b1;
        end else begin
            st_d.mode = dec_mode;
            st_d.refs = dec_refs;
            st_d.xref = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ctrl: '0, code: '0, mode: MODE_FREE, refs: '0, xref: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_now    = st_q.ctrl;
    assign mode_o      = st_q.mode;
    assign ref_sel_o   = {st_q.xref, st_q.refs};
    assign reg_rdata_o = {cfg_valid_o, cfg_src, st_q.xref, st_q.mode, st_q.code};

endmodule

// File: rtl/refsel_chk.sv
module refsel_chk #(
    parameter int SEL_W   = 4,
    parameter int NUM_REF = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       mode_o,
    input logic [NUM_REF:0] ref_sel_o,
    input logic             cfg_valid_o,
    input logic             hw_s,
    input logic             master_s,
    input logic             reg_wr_i,
    input logic [SEL_W-1:0] ctrl_now
);

    // R11
    p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ref_sel_o));

    // R8
    p_free_until_cfg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_valid_o |-> (mode_o == 2'b00 && ref_sel_o == '0));

    // R8
    p_cfg_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_valid_o |=> cfg_valid_o);

    // R3
    p_lock_has_ref_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'b01) |-> ($countones(ref_sel_o) == 1));

    // R4
    p_no_ref_unlocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o != 2'b01) |-> (ref_sel_o == '0));

    // R7
    p_slave_xref_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_valid_o && !master_s) |=> (mode_o == 2'b01 && ref_sel_o[NUM_REF]));

    // R5
    p_hw_write_dropped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_s && reg_wr_i) |=> $stable(ctrl_now));

endmodule

bind ref_mode_ctrl refsel_chk #(
    .SEL_W   (SEL_W),
    .NUM_REF (NUM_REF)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_o      (mode_o),
    .ref_sel_o   (ref_sel_o),
    .cfg_valid_o (cfg_valid_o),
    .hw_s        (hw_s),
    .master_s    (master_s),
    .reg_wr_i    (reg_wr_i),
    .ctrl_now    (ctrl_now)
);

// File: tb/sim_ref_mode_ctrl.sv
`timescale 1ns/1ps
module sim_ref_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hw_ovr, master, cfg_src, cfg_done, reg_wr;
    logic [3:0] sel, wdata;
    logic [1:0] mode;
    logic [8:0] ref_sel;
    logic       cfg_valid;
    logic [8:0] rdata;

    int    checks = 0;
    int    errors = 0;
    string tag    = "R1";

    always #2 clk = ~clk;

    ref_mode_ctrl u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hw_ovr_i    (hw_ovr),
        .master_i    (master),
        .sel_i       (sel),
        .cfg_src_i   (cfg_src),
        .cfg_done_i  (cfg_done),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (wdata),
        .mode_o      (mode),
        .ref_sel_o   (ref_sel),
        .cfg_valid_o (cfg_valid),
        .reg_rdata_o (rdata)
    );

    // Behavioural reference model, advanced on each rising edge
    logic [5:0] m_p1, m_p2;
    logic [3:0] m_ctrl, m_code;
    logic [1:0] m_mode;
    logic [8:0] m_ref;
    logic       m_valid, m_src;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_ctrl = 0; m_code = 0;
            m_mode = 0; m_ref = 0; m_valid = 0; m_src = 0;
        end else begin
            int src;
            src = m_p2[5] ? int'(m_p2[3:0]) : int'(m_ctrl);
            if (!m_valid) begin
                m_mode = 2'b00; m_ref = 0;
            end else if (!m_p2[4]) begin
                m_mode = 2'b01; m_ref = 9'h100;
            end else if (src == 0) begin
                m_mode = 2'b00; m_ref = 0;
            end else if (src <= 8) begin
                m_mode = 2'b01; m_ref = 9'(1 << (src - 1));
            end else begin
                m_mode = 2'b10; m_ref = 0;
            end
            m_code = 4'(src);
            if (reg_wr && !m_p2[5]) m_ctrl = wdata;
            if (cfg_done) begin
                m_valid = 1'b1;
                m_src   = cfg_src;
            end
            m_p2 = m_p1;
            m_p1 = {hw_ovr, master, sel};
        end
    end

    task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    // Wait to the falling edge, compare against the model, return for driving
    task automatic step();
        @(negedge clk);
        chk(tag, "model mode", 32'(mode), 32'(m_mode));
        chk(tag, "model ref_sel", 32'(ref_sel), 32'(m_ref));
        chk(tag, "model valid", 32'(cfg_valid), 32'(m_valid));
        chk(tag, "model rdata", 32'(rdata),
            32'({m_valid, m_src, m_ref[8], m_mode, m_code}));
        chk("R11", "onehot", 32'($countones(ref_sel) <= 1), 32'd1);
    endtask

    function automatic logic [1:0] exp_mode(int c);
        if (c == 0) return 2'b00;
        if (c <= 8) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [8:0] exp_ref(int c);
        if (c >= 1 && c <= 8) return 9'(1 << (c - 1));
        return 9'h000;
    endfunction

    function automatic string code_tag(int c);
        if (c == 0) return "R2";
        if (c <= 8) return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hw_ovr = 0; master = 0; sel = 0;
        cfg_src = 0; cfg_done = 0; reg_wr = 0; wdata = 0;
        repeat (3) step();
        tag = "R1";
        chk("R1", "mode", 32'(mode), 0);
        chk("R1", "ref_sel", 32'(ref_sel), 0);
        chk("R1", "valid", 32'(cfg_valid), 0);
        chk("R1", "rdata", 32'(rdata), 0);
        rst_n = 1'b1;
        master = 1'b1;
        step();

        // R8: register write before configuration has no visible mode effect
        tag = "R8";
        reg_wr = 1; wdata = 4'd3;
        step();
        reg_wr = 0;
        repeat (4) step();
        chk("R8", "mode before cfg", 32'(mode), 0);
        chk("R8", "valid before cfg", 32'(cfg_valid), 0);
        cfg_done = 1; cfg_src = 1;
        step();
        cfg_done = 0; cfg_src = 0;
        chk("R8", "valid set", 32'(cfg_valid), 1);
        chk("R10", "cfg_src field", 32'(rdata[7]), 1);
        step();
        chk("R6", "mode from register", 32'(mode), 32'(2'b01));
        chk("R6", "ref from register", 32'(ref_sel), 32'(9'h004));
        chk("R10", "code field", 32'(rdata[3:0]), 3);

        // R2/R3/R4/R6: every code through the register
        for (int c = 0; c < 16; c++) begin
            tag = code_tag(c);
            reg_wr = 1; wdata = 4'(c);
            step();
            reg_wr = 0;
            step();
            chk(code_tag(c), "reg mode", 32'(mode), 32'(exp_mode(c)));
            chk(code_tag(c), "reg ref", 32'(ref_sel), 32'(exp_ref(c)));
            chk("R10", "reg rdata", 32'(rdata),
                32'({1'b1, 1'b1, 1'b0, exp_mode(c), 4'(c)}));
        end

        // R5: pins in control
        tag = "R5";
        hw_ovr = 1;
        for (int c = 0; c < 16; c++) begin
            sel = 4'(c);
            repeat (3) step();
            chk("R5", "pin mode", 32'(mode), 32'(exp_mode(c)));
            chk("R5", "pin ref", 32'(ref_sel), 32'(exp_ref(c)));
            chk("R10", "pin code field", 32'(rdata[3:0]), 32'(c));
        end
        reg_wr = 1; wdata = 4'd5;
        step();
        reg_wr = 0; hw_ovr = 0;
        repeat (3) step();
        chk("R5", "register kept after dropped write", 32'(rdata[3:0]), 15);
        chk("R5", "mode after release", 32'(mode), 32'(2'b10));

        // R9: pin latency of three edges
        tag = "R9";
        hw_ovr = 1; sel = 4'd1;
        repeat (4) step();
        sel = 4'd2;
        step();
        chk("R9", "edge1 old", 32'(ref_sel), 32'(9'h001));
        step();
        chk("R9", "edge2 old", 32'(ref_sel), 32'(9'h001));
        step();
        chk("R9", "edge3 new", 32'(ref_sel), 32'(9'h002));

        // R7: slave forces cross-couple lock
        tag = "R7";
        master = 0; sel = 4'd0;
        repeat (4) step();
        chk("R7", "slave mode", 32'(mode), 32'(2'b01));
        chk("R7", "slave ref", 32'(ref_sel), 32'(9'h100));
        chk("R10", "xref field", 32'(rdata[6]), 1);
        master = 1; sel = 4'd2;
        repeat (4) step();

        // R8: reset clears configuration; reload from bus
        tag = "R8";
        rst_n = 0;
        step();
        chk("R8", "valid after reset", 32'(cfg_valid), 0);
        chk("R1", "mode after reset", 32'(mode), 0);
        rst_n = 1;
        repeat (4) step();
        chk("R8", "free until reload", 32'(mode), 0);
        cfg_done = 1; cfg_src = 0;
        step();
        cfg_done = 0;
        step();
        chk("R8", "valid after reload", 32'(cfg_valid), 1);
        chk("R10", "bus source", 32'(rdata[7]), 0);
        chk("R5", "pins after reload", 32'(ref_sel), 32'(9'h002));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule